// File: doc/BRIEF.md
# Serial LCD Bring-Up and Shutdown Sequencer

This block powers a small LCD panel's driver IC up and down over a serial link that only writes. The link carries 9-bit words. A request pulse starts a fixed script held in an on-chip ROM. The script contains timed pauses and single-command frames. It also contains register writes that carry one data byte or a 16-bit value. At the end of the bring-up script the block reports that the panel is active. A disable request runs a short teardown script that blanks the display and puts the panel to sleep.

The pause lengths are derived from a clock-frequency parameter, so a test can shrink them. The serial clock rate comes from a half-bit parameter. Host logic only pulses the enable or disable input and watches `busy`, `done` and `active`.

Top module: `lcd_init_seq`

## Requirements
- R1: Each serial word is 9 bits and is sent MSB first. Bit 8 is 0 for a command (register address) and 1 for a data byte; bits 7..0 hold the value. MOSI changes only while SCLK is low, the slave samples on the rising SCLK edge, and SCLK is low whenever CS_N is high.
- R2: A frame is one CS_N-low period and has one of three forms: a command alone (1 word), a command then one data byte (2 words), or a command then a 16-bit value (3 words, high byte before low byte).
- R3: After an accepted enable, the first frame starts no earlier than the power-up delay of 90 ms worth of clock ticks.
- R4: The bring-up opens with three command frames of 0x00. Each one is followed by a pause of at least 1 s worth of ticks before the next frame starts.
- R5: The bring-up frames then follow a fixed order. They start with 0xB0=0x17, 0xBC=0x80, 0x3B=0x00, 0xB0=0x16, the 16-bit write 0xB8=0xFFF9 and command 0x11. Next comes the panel register table, in which 0xB3=0x11 appears twice. The last frame is command 0x29.
- R6: `busy` is high while a script runs. `active` stays low through every bring-up frame and rises together with a one-cycle `done` pulse after the 0x29 frame ends.
- R7: Teardown sends command 0x28, then the 16-bit write 0xB8=0x8002, then command 0x10, then 0xB0=0x00. `active` drops as soon as the disable is accepted, and `done` pulses at the end.
- R8: Enable or disable pulses that arrive while `busy` is high have no effect on the frame stream or on `active`.
- R9: An enable while `active` is high, or a disable while `active` is low, gives a `done` pulse within 3 cycles. No CS_N activity follows and `busy` stays low.
- R10: CS_N stays high for at least one bit time (2*HALF_BIT clocks) between frames.
- R11: After reset, CS_N is high, SCLK is low and `busy`, `done` and `active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Bring-up request pulse |
| dis_req | input | 1 | Teardown request pulse |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle completion pulse |
| active | output | 1 | Panel brought up and not yet torn down |
| cs_n | output | 1 | Serial chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the panel |

## Verification
A wrong ROM index or word counter shows up as a mismatched frame at the very next CS_N rise. It appears as a wrong address, a missing data word or a misplaced data flag. A faulty delay count moves the start of the first frame, or of the frames after the 0x00 commands, outside a window only a few cycles wide. An error in the request gating or in the `active` flag shows within three cycles as a missing or extra `done`. It can also show as stray CS_N activity, or as `active` changing in the middle of a script.

// File: rtl/lcd_init_seq.sv
module lcd_init_seq #(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned PWR_MS   = 90,
  parameter int unsigned PAUSE_MS = 1000,
  parameter int unsigned HALF_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  output logic busy,
  output logic done,
  output logic active,
  output logic cs_n,
  output logic sclk,
  output logic mosi
);
  localparam int unsigned TICK_MS = CLK_HZ / 1000;
  localparam logic [31:0] PWR_M1   = 32'(TICK_MS * PWR_MS - 1);
  localparam logic [31:0] PAUSE_M1 = 32'(TICK_MS * PAUSE_MS - 1);
  localparam logic [31:0] HALF_M1  = 32'(HALF_BIT - 1);
  localparam logic [31:0] GAP_M1   = 32'(2 * HALF_BIT - 1);
  localparam logic [5:0] INIT_LAST  = 6'd47;
  localparam logic [5:0] SHUT_FIRST = 6'd48;
  localparam logic [5:0] SHUT_LAST  = 6'd51;
  localparam logic [1:0] K_CMD = 2'd0, K_W8 = 2'd1, K_W16 = 2'd2, K_DLY = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOW, S_HIGH, S_HOLD} st_t;

  function automatic logic [25:0] rom_at(input logic [5:0] i);
    case (i)
      6'd0:  rom_at = {K_DLY, 8'h00, 16'h0000};
      6'd1:  rom_at = {K_CMD, 8'h00, 16'h0000};
      6'd2:  rom_at = {K_DLY, 8'h00, 16'h0001};
      6'd3:  rom_at = {K_CMD, 8'h00, 16'h0000};
      6'd4:  rom_at = {K_DLY, 8'h00, 16'h0001};
      6'd5:  rom_at = {K_CMD, 8'h00, 16'h0000};
      6'd6:  rom_at = {K_DLY, 8'h00, 16'h0001};
      6'd7:  rom_at = {K_W8,  8'hB0, 16'h0017};
      6'd8:  rom_at = {K_W8,  8'hBC, 16'h0080};
      6'd9:  rom_at = {K_W8,  8'h3B, 16'h0000};
      6'd10: rom_at = {K_W8,  8'hB0, 16'h0016};
      6'd11: rom_at = {K_W16, 8'hB8, 16'hFFF9};
      6'd12: rom_at = {K_CMD, 8'h11, 16'h0000};
      6'd13: rom_at = {K_W8,  8'hBA, 16'h0001};
      6'd14: rom_at = {K_W8,  8'hBB, 16'h0000};
      6'd15: rom_at = {K_W8,  8'h3A, 16'h0060};
      6'd16: rom_at = {K_W8,  8'hBF, 16'h0010};
      6'd17: rom_at = {K_W8,  8'hB1, 16'h0056};
      6'd18: rom_at = {K_W8,  8'hB2, 16'h0033};
      6'd19: rom_at = {K_W8,  8'hB3, 16'h0011};
      6'd20: rom_at = {K_W8,  8'hB3, 16'h0011};
      6'd21: rom_at = {K_W8,  8'hB4, 16'h0002};
      6'd22: rom_at = {K_W8,  8'hB5, 16'h002B};
      6'd23: rom_at = {K_W8,  8'hB6, 16'h0040};
      6'd24: rom_at = {K_W8,  8'hB7, 16'h0003};
      6'd25: rom_at = {K_W8,  8'hB9, 16'h0004};
      6'd26: rom_at = {K_W8,  8'hBD, 16'h0004};
      6'd27: rom_at = {K_W8,  8'hBE, 16'h0000};
      6'd28: rom_at = {K_W8,  8'hC0, 16'h0011};
      6'd29: rom_at = {K_W8,  8'hC1, 16'h0011};
      6'd30: rom_at = {K_W8,  8'hC2, 16'h0011};
      6'd31: rom_at = {K_W16, 8'hC3, 16'h2040};
      6'd32: rom_at = {K_W16, 8'hC4, 16'h60C0};
      6'd33: rom_at = {K_W16, 8'hC5, 16'h1020};
      6'd34: rom_at = {K_W16, 8'hC6, 16'h60C0};
      6'd35: rom_at = {K_W16, 8'hC7, 16'h5533};
      6'd36: rom_at = {K_W8,  8'hC8, 16'h0000};
      6'd37: rom_at = {K_W8,  8'hC9, 16'h0000};
      6'd38: rom_at = {K_W8,  8'hCA, 16'h0000};
      6'd39: rom_at = {K_W16, 8'hEC, 16'h01F0};
      6'd40: rom_at = {K_W8,  8'hCF, 16'h0002};
      6'd41: rom_at = {K_W16, 8'hD0, 16'h0804};
      6'd42: rom_at = {K_W8,  8'hD1, 16'h0001};
      6'd43: rom_at = {K_W16, 8'hD2, 16'h0000};
      6'd44: rom_at = {K_W16, 8'hD3, 16'h0D0E};
      6'd45: rom_at = {K_W16, 8'hD4, 16'h11A4};
      6'd46: rom_at = {K_W8,  8'hD5, 16'h000E};
      6'd47: rom_at = {K_CMD, 8'h29, 16'h0000};
      6'd48: rom_at = {K_CMD, 8'h28, 16'h0000};
      6'd49: rom_at = {K_W16, 8'hB8, 16'h8002};
      6'd50: rom_at = {K_CMD, 8'h10, 16'h0000};
      6'd51: rom_at = {K_W8,  8'hB0, 16'h0000};
      default: rom_at = {K_CMD, 8'h00, 16'h0000};
    endcase
  endfunction

  st_t st;
  logic [5:0]  pc;
  logic [31:0] cnt;
  logic [1:0]  wi;
  logic [3:0]  bi;
  logic        shut;

  logic [25:0] ent;
  logic [1:0]  kind;
  logic [7:0]  addr;
  logic [15:0] val;
  logic [8:0]  word;
  logic        seq_end;

  assign ent     = rom_at(pc);
  assign kind    = ent[25:24];
  assign addr    = ent[23:16];
  assign val     = ent[15:0];
  assign word    = (wi == 2'd0) ? {1'b0, addr} :
                   (wi == 2'd1 && kind == K_W16) ? {1'b1, val[15:8]} : {1'b1, val[7:0]};
  assign mosi    = ~cs_n & word[bi];
  assign seq_end = (pc == (shut ? SHUT_LAST : INIT_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pc <= '0; cnt <= '0; wi <= '0; bi <= '0; shut <= 1'b0;
      busy <= 1'b0; done <= 1'b0; active <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (en_req) begin
            if (active) done <= 1'b1;
            else begin busy <= 1'b1; shut <= 1'b0; pc <= '0; st <= S_FETCH; end
          end else if (dis_req) begin
            if (!active) done <= 1'b1;
            else begin
              busy <= 1'b1; active <= 1'b0; shut <= 1'b1; pc <= SHUT_FIRST; st <= S_FETCH;
            end
          end
        S_FETCH:
          if (kind == K_DLY) begin
            cnt <= (val == 16'd0) ? PWR_M1 : PAUSE_M1;
            st  <= S_HOLD;
          end else begin
            cs_n <= 1'b0; wi <= '0; bi <= 4'd8; cnt <= HALF_M1; st <= S_LOW;
          end
        S_LOW:
          if (cnt == '0) begin sclk <= 1'b1; cnt <= HALF_M1; st <= S_HIGH; end
          else cnt <= cnt - 1'b1;
        S_HIGH:
          if (cnt == '0) begin
            sclk <= 1'b0;
            cnt  <= HALF_M1;
            st   <= S_LOW;
            if (bi != 4'd0) bi <= bi - 1'b1;
            else if (wi != kind) begin wi <= wi + 1'b1; bi <= 4'd8; end
            else begin cs_n <= 1'b1; cnt <= GAP_M1; st <= S_HOLD; end
          end else cnt <= cnt - 1'b1;
        S_HOLD:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (seq_end) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b1;
            if (!shut) active <= 1'b1;
          end else begin
            pc <= pc + 1'b1; st <= S_FETCH;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |=> cs_n);
  assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(active));
  assert_frame_busy_R6: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> busy);
endmodule

// File: tb/lcd_init_seq_tb_top.sv
module lcd_init_seq_tb_top;
  localparam int unsigned HZ = 5000;
  localparam int unsigned HB = 2;
  localparam longint T_PWR = 450;
  localparam longint T_PAUSE = 5000;

  logic clk = 1'b0, rst_n = 1'b0, en_req = 1'b0, dis_req = 1'b0;
  logic busy, done, active, cs_n, sclk, mosi;
  int total = 0, bad = 0;
  longint cyc = 0, en_cyc = 0, rise_cyc = 0;
  int fidx = 0, cs_falls = 0, nbits = 0;
  bit shut_op = 0, in_frame = 0, have_rise = 0;
  logic [26:0] fbuf;

  lcd_init_seq #(.CLK_HZ(HZ), .HALF_BIT(HB)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .busy(busy),
    .done(done), .active(active), .cs_n(cs_n), .sclk(sclk), .mosi(mosi));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 command only, 1 byte write, 2 16-bit write
  function automatic logic [25:0] exp_frame(input bit sh, input int k);
    if (sh) case (k)
      0: return {2'd0, 8'h28, 16'h0};
      1: return {2'd2, 8'hB8, 16'h8002};
      2: return {2'd0, 8'h10, 16'h0};
      default: return {2'd1, 8'hB0, 16'h0};
    endcase
    case (k)
      0, 1, 2: return {2'd0, 8'h00, 16'h0};
      3: return {2'd1, 8'hB0, 16'h17};   4: return {2'd1, 8'hBC, 16'h80};
      5: return {2'd1, 8'h3B, 16'h00};   6: return {2'd1, 8'hB0, 16'h16};
      7: return {2'd2, 8'hB8, 16'hFFF9}; 8: return {2'd0, 8'h11, 16'h0};
      9: return {2'd1, 8'hBA, 16'h01};   10: return {2'd1, 8'hBB, 16'h00};
      11: return {2'd1, 8'h3A, 16'h60};  12: return {2'd1, 8'hBF, 16'h10};
      13: return {2'd1, 8'hB1, 16'h56};  14: return {2'd1, 8'hB2, 16'h33};
      15, 16: return {2'd1, 8'hB3, 16'h11};
      17: return {2'd1, 8'hB4, 16'h02};  18: return {2'd1, 8'hB5, 16'h2B};
      19: return {2'd1, 8'hB6, 16'h40};  20: return {2'd1, 8'hB7, 16'h03};
      21: return {2'd1, 8'hB9, 16'h04};  22: return {2'd1, 8'hBD, 16'h04};
      23: return {2'd1, 8'hBE, 16'h00};  24: return {2'd1, 8'hC0, 16'h11};
      25: return {2'd1, 8'hC1, 16'h11};  26: return {2'd1, 8'hC2, 16'h11};
      27: return {2'd2, 8'hC3, 16'h2040}; 28: return {2'd2, 8'hC4, 16'h60C0};
      29: return {2'd2, 8'hC5, 16'h1020}; 30: return {2'd2, 8'hC6, 16'h60C0};
      31: return {2'd2, 8'hC7, 16'h5533}; 32: return {2'd1, 8'hC8, 16'h00};
      33: return {2'd1, 8'hC9, 16'h00};  34: return {2'd1, 8'hCA, 16'h00};
      35: return {2'd2, 8'hEC, 16'h01F0}; 36: return {2'd1, 8'hCF, 16'h02};
      37: return {2'd2, 8'hD0, 16'h0804}; 38: return {2'd1, 8'hD1, 16'h01};
      39: return {2'd2, 8'hD2, 16'h0000}; 40: return {2'd2, 8'hD3, 16'h0D0E};
      41: return {2'd2, 8'hD4, 16'h11A4}; 42: return {2'd1, 8'hD5, 16'h0E};
      default: return {2'd0, 8'h29, 16'h0};
    endcase
  endfunction

  function automatic logic [26:0] exp_bits(input logic [25:0] e, output int n);
    case (e[25:24])
      2'd0: begin n = 9;  return {18'd0, 1'b0, e[23:16]}; end
      2'd1: begin n = 18; return {9'd0, 1'b0, e[23:16], 1'b1, e[7:0]}; end
      default: begin n = 27; return {1'b0, e[23:16], 1'b1, e[15:8], 1'b1, e[7:0]}; end
    endcase
  endfunction

  always @(negedge cs_n) if (rst_n) begin
    longint gap;
    in_frame = 1; nbits = 0; fbuf = '0; cs_falls++;
    gap = cyc - rise_cyc;
    if (fidx == 0 && !shut_op)
      chk(cyc - en_cyc >= T_PWR && cyc - en_cyc <= T_PWR + 6, "R3", "power-up wait", cyc - en_cyc, T_PWR);
    else if (have_rise && !shut_op && fidx >= 1 && fidx <= 3)
      chk(gap >= T_PAUSE && gap <= T_PAUSE + 2*HB + 6, "R4", "pause after 0x00", gap, T_PAUSE);
    else if (have_rise)
      chk(gap >= 2*HB, "R10", "cs high gap", gap, 2*HB);
  end

  always @(posedge sclk) if (!cs_n) begin
    fbuf = {fbuf[25:0], mosi};
    nbits++;
  end

  always @(posedge cs_n) if (in_frame) begin
    int n;
    logic [26:0] eb;
    in_frame = 0; have_rise = 1; rise_cyc = cyc;
    eb = exp_bits(exp_frame(shut_op, fidx), n);
    chk(nbits == n, shut_op ? "R7" : "R2", "frame bit count", nbits, n);
    chk(fbuf == eb, shut_op ? "R7" : "R5", $sformatf("frame %0d words", fidx), fbuf, eb);
    if (!shut_op) chk(active == 1'b0, "R6", "active during bring-up", active, 0);
    fidx++;
  end

  task automatic pulse(input bit en);
    @(negedge clk);
    if (en) en_req = 1; else dis_req = 1;
    en_cyc = cyc;
    @(negedge clk);
    en_req = 0; dis_req = 0;
  endtask

  task automatic run_script(input bit sh, input int frames);
    int next_poke;
    bit got;
    fidx = 0; shut_op = sh; have_rise = 0; got = 0;
    pulse(!sh);
    if (sh) chk(active == 0 && busy == 1, "R7", "active drops on accept", active, 0);
    else chk(busy == 1, "R6", "busy during bring-up", busy, 1);
    next_poke = 50 + ($urandom % 400);
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
      if (i == next_poke) begin
        if ($urandom % 2) en_req = 1; else dis_req = 1;
        @(negedge clk);
        en_req = 0; dis_req = 0;
        next_poke = i + 100 + ($urandom % 3000);
        if (done) begin got = 1; break; end
      end
    end
    chk(got, "R6", "done pulse seen", got, 1);
    chk(fidx == frames, "R8", "frame count", fidx, frames);
    chk(active == !sh, sh ? "R7" : "R6", "active after script", active, !sh);
    chk(busy == 0, "R6", "busy cleared", busy, 0);
  endtask

  task automatic noop_req(input bit en);
    int c0;
    bit got, bz;
    c0 = cs_falls; got = 0; bz = 0;
    pulse(en);
    for (int i = 0; i < 3; i++) begin
      if (done) got = 1;
      if (busy) bz = 1;
      if (!got) @(negedge clk);
    end
    if (done) got = 1;
    chk(got, "R9", "immediate done", got, 1);
    repeat (50) begin @(negedge clk); if (busy) bz = 1; end
    chk(!bz, "R9", "busy stays low", bz, 0);
    chk(cs_falls == c0, "R9", "no serial traffic", cs_falls - c0, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R11", "reset link idle", {cs_n, sclk}, 2'b10);
    chk(busy === 0 && done === 0 && active === 0, "R11", "reset status", {busy, done, active}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    noop_req(0);
    run_script(0, 44);
    noop_req(1);
    run_script(1, 4);
    noop_req(0);
    run_script(0, 44);
    run_script(1, 4);
    chk(cs_n == 1 && sclk == 0, "R1", "link idle at end", {cs_n, sclk}, 2'b10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R6 actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule